// File: doc/BRIEF.md
# Two-way unrolled string-copy lane masker

This block is the mask datapath of a string copy that has been unrolled by two. Each cycle it can accept a pair of loaded byte vectors, A followed by B in address order. It finds the zero terminator in each vector and works out which lanes of each vector should be written to memory. It returns two masked store vectors with per-lane keep bits, plus one flag that tells the loop to stop.

Within a vector, every lane up to and including the first zero byte is kept, so the terminator itself is copied. Every later lane is marked empty: its keep bit is cleared and its data byte is forced to zero. Vector B depends on vector A. If A already held a terminator, B is empty in every lane. Otherwise B is masked in the same way as A.

The datapath has three register stages: compare, smear, and select/mask. A new pair can enter on every cycle. A valid bit travels with each pair through the pipeline. Lane 0 is the lowest address.

Top module: `strcpy_lane_mask`

## Requirements
- R1: While reset is asserted, and after reset until the first valid pair comes out, `out_valid_o`, both keep vectors and `exit_o` are all zero.
- R2: A pair presented with `in_valid_i` high on a clock edge comes out with `out_valid_o` high exactly three clock edges later. Bubbles are kept in the same positions.
- R3: In store vector A, keep bit i is 1 when lane i is at or below the lowest lane holding a zero byte, and 0 otherwise. If no lane holds zero, all keep bits are 1.
- R4: In both store vectors, every lane whose keep bit is 0 has a data byte of 0. Every lane whose keep bit is 1 carries the loaded byte unchanged.
- R5: If vector A holds any zero byte, every keep bit of store vector B is 0.
- R6: If vector A holds no zero byte, store vector B's keep bits follow the rule of R3, applied to vector B.
- R7: `exit_o` is 1 when vector A or vector B, or both, hold a zero byte.
- R8: Pairs presented on consecutive cycles each produce their own independent result on consecutive cycles.
- R9: On any cycle where `out_valid_o` is 0, both keep vectors and `exit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The input pair is valid |
| vec_a_i | input | LANES*8 | First loaded vector; lane 0 in bits 7:0 |
| vec_b_i | input | LANES*8 | Second loaded vector |
| out_valid_o | output | 1 | The output pair is valid |
| store_a_data_o | output | LANES*8 | Masked data for store A |
| store_a_keep_o | output | LANES | Per-lane write enable for store A |
| store_b_data_o | output | LANES*8 | Masked data for store B |
| store_b_keep_o | output | LANES | Per-lane write enable for store B |
| exit_o | output | 1 | Loop-exit flag |

## Verification
The bench builds the block with LANES=4. This makes it possible to sweep all 256 combinations of zero and nonzero lanes across the two vectors. The sweep covers the terminator in every lane of each vector, in both vectors, in neither, and repeated zeros in one vector. Pairs are fed back to back, and a bubble is inserted every seventh cycle. This exercises throughput, the alignment of valid bits, and idle outputs alongside the masking rules.

// File: rtl/strcpy_lane_mask_pkg.sv
package strcpy_lane_mask_pkg;
  localparam int unsigned BYTE_W = 8;

  // pipeline depth from input edge to registered outputs
  localparam int unsigned PIPE_STAGES = 3;
endpackage

// File: rtl/slm_zero_detect.sv
module slm_zero_detect #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned VEC_W = LANES * BYTE_W
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [LANES-1:0] hit_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit_o[l] = (vec_i[l*BYTE_W +: BYTE_W] == '0);
  end
endmodule

// File: rtl/slm_smear.sv
module slm_smear #(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES-1:0] hit_i,
  output logic [LANES-1:0] keep_o,
  output logic             done_o
);
  // seen[l] is set if any lane below l held a terminator
  logic [LANES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar l = 0; l < LANES; l++) begin : g_chain
    assign seen[l+1] = seen[l] | hit_i[l];
    assign keep_o[l] = ~seen[l];
  end

  assign done_o = seen[LANES];
endmodule

// File: rtl/slm_apply_mask.sv
module slm_apply_mask #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned VEC_W = LANES * BYTE_W
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [LANES-1:0] keep_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vec_o[l*BYTE_W +: BYTE_W] =
      keep_i[l] ? vec_i[l*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/strcpy_lane_mask.sv
module strcpy_lane_mask
  import strcpy_lane_mask_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned VEC_W = LANES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [VEC_W-1:0] vec_a_i,
  input  logic [VEC_W-1:0] vec_b_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] store_a_data_o,
  output logic [LANES-1:0] store_a_keep_o,
  output logic [VEC_W-1:0] store_b_data_o,
  output logic [LANES-1:0] store_b_keep_o,
  output logic             exit_o
);
  localparam int unsigned NVEC = 2;

  // stage 1: compare
  logic [VEC_W-1:0] in_vec  [NVEC];
  logic [LANES-1:0] hit_d   [NVEC];
  logic [VEC_W-1:0] s1_vec_q[NVEC];
  logic [LANES-1:0] s1_hit_q[NVEC];
  logic             s1_valid_q;

  // stage 2: smear
  logic [LANES-1:0] keep_d   [NVEC];
  logic             done_d   [NVEC];
  logic [VEC_W-1:0] s2_vec_q [NVEC];
  logic [LANES-1:0] s2_keep_q[NVEC];
  logic             s2_done_q[NVEC];
  logic             s2_valid_q;

  // stage 3: select and mask
  logic [LANES-1:0] ctrl_d[NVEC];
  logic [VEC_W-1:0] mask_d[NVEC];

  assign in_vec[0] = vec_a_i;
  assign in_vec[1] = vec_b_i;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    slm_zero_detect #(.LANES(LANES), .BYTE_W(BYTE_W)) i_detect (
      .vec_i (in_vec[v]),
      .hit_o (hit_d[v])
    );

    slm_smear #(.LANES(LANES)) i_smear (
      .hit_i  (s1_hit_q[v]),
      .keep_o (keep_d[v]),
      .done_o (done_d[v])
    );

    slm_apply_mask #(.LANES(LANES), .BYTE_W(BYTE_W)) i_apply (
      .vec_i  (s2_vec_q[v]),
      .keep_i (ctrl_d[v]),
      .vec_o  (mask_d[v])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_vec_q[v]  <= '0;
        s1_hit_q[v]  <= '0;
        s2_vec_q[v]  <= '0;
        s2_keep_q[v] <= '0;
        s2_done_q[v] <= 1'b0;
      end else begin
        s1_vec_q[v]  <= in_vec[v];
        s1_hit_q[v]  <= hit_d[v];
        s2_vec_q[v]  <= s1_vec_q[v];
        s2_keep_q[v] <= keep_d[v];
        s2_done_q[v] <= done_d[v];
      end
    end
  end

  // the second store is all empty once the first vector has terminated
  assign ctrl_d[0] = s2_keep_q[0];
  assign ctrl_d[1] = s2_done_q[0] ? '0 : s2_keep_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q     <= 1'b0;
      s2_valid_q     <= 1'b0;
      out_valid_o    <= 1'b0;
      store_a_data_o <= '0;
      store_a_keep_o <= '0;
      store_b_data_o <= '0;
      store_b_keep_o <= '0;
      exit_o         <= 1'b0;
    end else begin
      s1_valid_q     <= in_valid_i;
      s2_valid_q     <= s1_valid_q;
      out_valid_o    <= s2_valid_q;
      // bubbles never enable a lane
      store_a_data_o <= mask_d[0];
      store_a_keep_o <= s2_valid_q ? ctrl_d[0] : '0;
      store_b_data_o <= mask_d[1];
      store_b_keep_o <= s2_valid_q ? ctrl_d[1] : '0;
      exit_o         <= s2_valid_q & (s2_done_q[0] | s2_done_q[1]);
    end
  end

  // ---------------- assertions ----------------
  function automatic logic term_kept(input logic [VEC_W-1:0] d,
                                     input logic [LANES-1:0] k);
    logic r = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (k[l] && d[l*BYTE_W +: BYTE_W] == '0) r = 1'b1;
    return r;
  endfunction

  function automatic logic empty_lanes_zero(input logic [VEC_W-1:0] d,
                                            input logic [LANES-1:0] k);
    logic r = 1'b1;
    for (int l = 0; l < LANES; l++)
      if (!k[l] && d[l*BYTE_W +: BYTE_W] != '0) r = 1'b0;
    return r;
  endfunction

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i, PIPE_STAGES));

  // R3
  smear_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_valid_q |-> (s2_keep_q[0][0] &&
                    ((s2_keep_q[0] & (s2_keep_q[0] + 1'b1)) == '0)));

  // R4
  empty_lane_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (empty_lanes_zero(store_a_data_o, store_a_keep_o) &&
                     empty_lanes_zero(store_b_data_o, store_b_keep_o)));

  // R5
  b_suppressed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && term_kept(store_a_data_o, store_a_keep_o))
      |-> store_b_keep_o == '0);

  // R7
  exit_on_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (term_kept(store_a_data_o, store_a_keep_o) ||
                     term_kept(store_b_data_o, store_b_keep_o))) |-> exit_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (store_a_keep_o == '0 && store_b_keep_o == '0 && !exit_o));
endmodule

// File: tb/test_strcpy_lane_mask.sv
`timescale 1ns/1ps
module test_strcpy_lane_mask;
  localparam int L = 4;
  localparam int W = L * 8;
  localparam int DEPTH = 1024;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] vec_a_i = '0, vec_b_i = '0;
  logic         out_valid_o, exit_o;
  logic [W-1:0] store_a_data_o, store_b_data_o;
  logic [L-1:0] store_a_keep_o, store_b_keep_o;

  int total = 0, bad = 0;

  logic         e_v [DEPTH];
  logic [W-1:0] e_da[DEPTH], e_db[DEPTH];
  logic [L-1:0] e_ka[DEPTH], e_kb[DEPTH];
  logic         e_x [DEPTH];

  always #2.5 clk_i = ~clk_i;

  strcpy_lane_mask #(.LANES(L)) i_strcpy_lane_mask (.*);

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                     input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // first zero lane index, L if none
  function automatic int first_zero(input logic [W-1:0] v);
    for (int l = 0; l < L; l++) if (v[l*8 +: 8] == 8'h00) return l;
    return L;
  endfunction

  function automatic logic [L-1:0] prefix(input int f);
    logic [L-1:0] k = '0;
    for (int l = 0; l < L; l++) if (l <= f) k[l] = 1'b1;
    return k;
  endfunction

  function automatic logic [W-1:0] zero_empty(input logic [W-1:0] v,
                                              input logic [L-1:0] k);
    logic [W-1:0] r = v;
    for (int l = 0; l < L; l++) if (!k[l]) r[l*8 +: 8] = 8'h00;
    return r;
  endfunction

  task automatic check_cycle(input int j);
    chk(W'(out_valid_o), W'(e_v[j]), "R2/R8 valid");
    chk(W'(store_a_keep_o), W'(e_ka[j]), "R3 keep_a");
    chk(W'(store_b_keep_o), W'(e_kb[j]), "R5/R6 keep_b");
    chk(W'(exit_o), W'(e_x[j]), "R7 exit");
    if (e_v[j]) begin
      chk(store_a_data_o, e_da[j], "R4 data_a");
      chk(store_b_data_o, e_db[j], "R4 data_b");
    end else begin
      chk(W'({store_a_keep_o, store_b_keep_o, exit_o}), '0, "R9 idle");
    end
  endtask

  initial begin
    #200_000;
    bad++;
    $display("FAIL R2 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int j = 0;
    int pair = 0;
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    chk(W'({out_valid_o, store_a_keep_o, store_b_keep_o, exit_o}), '0, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(W'({out_valid_o, store_a_keep_o, store_b_keep_o, exit_o}), '0, "R1 after reset");

    while (pair < 256 || j < 3 || e_v[j-1] || e_v[j-2] || e_v[j-3]) begin
      if (j >= 3) check_cycle(j - 3);
      if (pair < 256 && (j % 7) != 6) begin
        logic [3:0] pa = pair[3:0];
        logic [3:0] pb = pair[7:4];
        logic [W-1:0] a, b;
        logic [L-1:0] ka, kb;
        int fa, fb;
        for (int l = 0; l < L; l++) begin
          a[l*8 +: 8] = pa[l] ? 8'h00 : 8'(8'h41 + 16 * l + pair[3:0]);
          b[l*8 +: 8] = pb[l] ? 8'h00 : 8'(8'h81 + 8 * l + pair[7:5]);
        end
        fa = first_zero(a);
        fb = first_zero(b);
        ka = prefix(fa);
        kb = (fa < L) ? '0 : prefix(fb);
        in_valid_i = 1'b1;
        vec_a_i = a;
        vec_b_i = b;
        e_v[j] = 1'b1;
        e_ka[j] = ka;
        e_kb[j] = kb;
        e_da[j] = zero_empty(a, ka);
        e_db[j] = zero_empty(b, kb);
        e_x[j] = (fa < L) || (fb < L);
        pair++;
      end else begin
        in_valid_i = 1'b0;
        vec_a_i = {L{8'h00}};
        vec_b_i = {L{8'h00}};
        e_v[j] = 1'b0;
        e_ka[j] = '0;
        e_kb[j] = '0;
        e_da[j] = '0;
        e_db[j] = '0;
        e_x[j] = 1'b0;
      end
      j++;
      @(negedge clk_i);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule